// File: doc/BRIEF.md
# Video Frame Downscaler with Freeze and Crop-Zoom

This block reduces a live stream of decoded RGB pixels (640 x 480 active area, 18-bit colour, about 60 frames per second) to a small display frame and writes it into a frame buffer. The output width is fixed at 120 pixels. The output height is 60 rows in the standard (4:3) aspect mode and 96 rows in the wide (16:9) mode. The input arrives as single pixels qualified by a valid strobe, with a start-of-frame marker on the first pixel of a frame and a start-of-line marker on the first pixel of every line. The output is a stream of buffer writes, each carrying a linear address and the pixel value.

Two viewing controls share the scaler. Freeze suppresses all buffer writes, so the buffer keeps showing the last frame that was written in full. Zoom picks a rectangle of the input (top-left corner plus width and height) and spreads it across the whole output. Both axes use error-accumulator stepping, so a ratio that is not an integer still selects samples evenly. Every control is sampled once per frame, on the start-of-frame pixel, so an output frame is never built from two settings.

Top module: `frame_downscaler`

## Requirements
- R1: After reset, and while no pixel is presented, wrEn stays low.
- R2: In standard mode with zoom off, one frame produces exactly OUT_W x OUT_H_STD writes; input column i (0-based) is kept exactly when floor((i+1)*OUT_W/IN_W) > floor(i*OUT_W/IN_W), and input row r is kept by the same rule using OUT_H_STD and IN_H.
- R3: In wide mode (modeWide=1) the kept rows follow the R2 rule with OUT_H_WIDE in place of OUT_H_STD, giving OUT_W x OUT_H_WIDE writes per frame.
- R4: Write addresses start at 0 on each frame and increase by one per write, in row-major order (row times OUT_W plus column), never reaching OUT_W x OUT_H_WIDE.
- R5: wrData equals the 18-bit input pixel of the kept sample, bit for bit, with red, green and blue at 6 bits each.
- R6: A frame whose start-of-frame pixel sees freeze=1 produces no writes at all; the next frame that starts with freeze=0 is written in full again.
- R7: Mode, freeze, zoom enable and the crop fields are sampled only on the start-of-frame pixel; changing them later in the frame does not change that frame's writes.
- R8: With zoom on, only input pixels inside the sampled crop rectangle are considered, and the R2 selection rule is applied relative to the rectangle's corner with its width and height in place of IN_W and IN_H.
- R9: The crop corner is clamped to at most IN_W-OUT_W horizontally and IN_H-OUT_H vertically (OUT_H of the sampled mode); the size is then limited to the room left in the frame and raised to at least OUT_W by OUT_H.
- R10: Cycles with inValid low are ignored: idle gaps inside or between lines do not change which pixels are written or their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel qualifier |
| inSof | input | 1 | First pixel of a frame (also starts a line) |
| inSol | input | 1 | First pixel of a line |
| inPix | input | PIX_W | Pixel value, red in the top 6 bits, blue in the bottom 6 |
| modeWide | input | 1 | 0 selects the standard output height, 1 the wide one |
| freeze | input | 1 | Suppress all writes of the next frame |
| zoomEn | input | 1 | Use the crop rectangle instead of the full frame |
| cropX | input | clog2(IN_W+1) | Crop left column |
| cropY | input | clog2(IN_H+1) | Crop top row |
| cropW | input | clog2(IN_W+1) | Crop width in pixels |
| cropH | input | clog2(IN_H+1) | Crop height in lines |
| wrEn | output | 1 | Frame buffer write strobe |
| wrAddr | output | clog2(OUT_W*OUT_H_WIDE) | Linear write address |
| wrData | output | PIX_W | Pixel written |

## Verification
The bench runs a scaled-down configuration (16 x 12 input to 5 x 3 or 5 x 7 output) and predicts every write of each frame from the floor-quotient selection rule, comparing address and data one by one. Full frames in both modes separate the two height ratios; a frame with idle gaps tells valid gating apart from plain cycle counting; a frozen frame followed by a live one shows that freeze gates whole frames; and a frame whose controls flip right after the start-of-frame pixel shows that settings are held per frame. A sweep of crop corners and sizes, many of them outside the frame, across both modes exercises the window mapping and every clamping branch.

// File: rtl/dscale_pkg.sv
package dscale_pkg;

  typedef enum logic {
    ASPECT_STD  = 1'b0,
    ASPECT_WIDE = 1'b1
  } aspect_e;

  // Per-pixel strobes from the control to the datapath.
  typedef struct packed {
    logic write;    // keep the pixel now in the stage register
    logic restart;  // that pixel opens a new frame
  } dscale_strb_t;

endpackage

// File: rtl/dscale_ctrl.sv
module dscale_ctrl
  import dscale_pkg::*;
#(
  parameter int IN_W       = 640,
  parameter int IN_H       = 480,
  parameter int OUT_W      = 120,
  parameter int OUT_H_STD  = 60,
  parameter int OUT_H_WIDE = 96,
  localparam int XW = $clog2(IN_W + 1),
  localparam int YW = $clog2(IN_H + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  input  logic          inSol,
  input  logic          modeWide,
  input  logic          freeze,
  input  logic          zoomEn,
  input  logic [XW-1:0] cropX,
  input  logic [YW-1:0] cropY,
  input  logic [XW-1:0] cropW,
  input  logic [YW-1:0] cropH,
  output dscale_strb_t  strb
);

  localparam logic [XW-1:0] IN_W_L    = XW'(IN_W);
  localparam logic [XW-1:0] OUT_W_L   = XW'(OUT_W);
  localparam logic [YW-1:0] IN_H_L    = YW'(IN_H);
  localparam logic [YW-1:0] OH_STD_L  = YW'(OUT_H_STD);
  localparam logic [YW-1:0] OH_WIDE_L = YW'(OUT_H_WIDE);

  // ---------------- frame settings, clamped at start of frame ----------------
  aspect_e       nMode;
  logic [YW-1:0] nOh;
  logic [XW-1:0] nCx, nCw, roomX;
  logic [YW-1:0] nCy, nCh, roomY;

  always_comb begin
    nMode = modeWide ? ASPECT_WIDE : ASPECT_STD;
    nOh   = (nMode == ASPECT_WIDE) ? OH_WIDE_L : OH_STD_L;
    if (zoomEn) begin
      nCx   = (cropX > IN_W_L - OUT_W_L) ? IN_W_L - OUT_W_L : cropX;
      roomX = IN_W_L - nCx;
      nCw   = (cropW > roomX) ? roomX : cropW;
      if (nCw < OUT_W_L) nCw = OUT_W_L;
      nCy   = (cropY > IN_H_L - nOh) ? IN_H_L - nOh : cropY;
      roomY = IN_H_L - nCy;
      nCh   = (cropH > roomY) ? roomY : cropH;
      if (nCh < nOh) nCh = nOh;
    end else begin
      nCx   = '0;
      roomX = IN_W_L;
      nCw   = IN_W_L;
      nCy   = '0;
      roomY = IN_H_L;
      nCh   = IN_H_L;
    end
  end

  logic [XW-1:0] cfgCx, cfgCw;
  logic [YW-1:0] cfgCy, cfgCh, cfgOh;
  logic          cfgFreeze;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCx     <= '0;
      cfgCw     <= IN_W_L;
      cfgCy     <= '0;
      cfgCh     <= IN_H_L;
      cfgOh     <= OH_STD_L;
      cfgFreeze <= 1'b0;
    end else if (inValid && inSof) begin
      cfgCx     <= nCx;
      cfgCw     <= nCw;
      cfgCy     <= nCy;
      cfgCh     <= nCh;
      cfgOh     <= nOh;
      cfgFreeze <= freeze;
    end
  end

  // ---------------- stage-1 markers and input coordinates ----------------
  logic s1Valid, s1Sof, s1Sol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Sof   <= 1'b0;
      s1Sol   <= 1'b0;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Sof <= inSof;
        s1Sol <= inSol | inSof;
      end
    end
  end

  logic          lineStart;
  logic [XW-1:0] xReg, curX;
  logic [YW-1:0] yReg, curY;

  assign lineStart = s1Sof | s1Sol;
  assign curX      = lineStart ? '0 : xReg;
  assign curY      = s1Sof ? '0 : (s1Sol ? yReg + 1'b1 : yReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else if (s1Valid) begin
      xReg <= curX + 1'b1;
      yReg <= curY;
    end
  end

  // ---------------- horizontal stepping ----------------
  logic [XW:0]   colEnd, hSum;
  logic [XW-1:0] hAcc, hAccEff, hNext;
  logic          inColWin, colHit;

  assign colEnd   = {1'b0, cfgCx} + {1'b0, cfgCw};
  assign inColWin = (curX >= cfgCx) && ({1'b0, curX} < colEnd);
  assign hAccEff  = lineStart ? '0 : hAcc;
  assign hSum     = {1'b0, hAccEff} + {1'b0, OUT_W_L};
  assign colHit   = inColWin && (hSum >= {1'b0, cfgCw});
  assign hNext    = colHit ? XW'(hSum - {1'b0, cfgCw}) : hSum[XW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hAcc <= '0;
    end else if (s1Valid) begin
      if (inColWin)       hAcc <= hNext;
      else if (lineStart) hAcc <= '0;
    end
  end

  // ---------------- vertical stepping, decided once per line ----------------
  logic [YW:0]   rowEnd, vSum;
  logic [YW-1:0] vAcc, vAccEff, vNext;
  logic          inRowWin, rowHitNow, rowHitReg, rowHit;

  assign rowEnd    = {1'b0, cfgCy} + {1'b0, cfgCh};
  assign inRowWin  = (curY >= cfgCy) && ({1'b0, curY} < rowEnd);
  assign vAccEff   = s1Sof ? '0 : vAcc;
  assign vSum      = {1'b0, vAccEff} + {1'b0, cfgOh};
  assign rowHitNow = inRowWin && (vSum >= {1'b0, cfgCh});
  assign vNext     = rowHitNow ? YW'(vSum - {1'b0, cfgCh}) : vSum[YW-1:0];
  assign rowHit    = lineStart ? rowHitNow : rowHitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vAcc      <= '0;
      rowHitReg <= 1'b0;
    end else if (s1Valid && lineStart) begin
      rowHitReg <= rowHitNow;
      if (inRowWin)   vAcc <= vNext;
      else if (s1Sof) vAcc <= '0;
    end
  end

  assign strb.write   = s1Valid && !cfgFreeze && rowHit && colHit;
  assign strb.restart = s1Valid && s1Sof;

  // ---------------- assertions ----------------
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inSof) |=> ($stable(cfgCx) && $stable(cfgCw) && $stable(cfgCy)
                             && $stable(cfgCh) && $stable(cfgOh) && $stable(cfgFreeze)));

  assert_window_fit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCw >= OUT_W_L) && (colEnd <= {1'b0, IN_W_L})
    && (cfgCh >= cfgOh) && (rowEnd <= {1'b0, IN_H_L}));

  assert_frozen_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgFreeze |-> !strb.write);

  assert_valid_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |-> !(strb.write || strb.restart));

endmodule

// File: rtl/dscale_datapath.sv
module dscale_datapath
  import dscale_pkg::*;
#(
  parameter int PIX_W  = 18,
  parameter int DEPTH  = 11520,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [PIX_W-1:0]  inPix,
  input  dscale_strb_t      strb,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PIX_W-1:0]  wrData
);

  logic [PIX_W-1:0]  pixS1;
  logic [ADDR_W-1:0] addrCnt, addrBase;

  always_ff @(posedge clk) begin
    if (inValid) pixS1 <= inPix;
  end

  assign addrBase = strb.restart ? '0 : addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrEn <= strb.write;
      if (strb.write) begin
        wrAddr  <= addrBase;
        wrData  <= pixS1;
        addrCnt <= addrBase + 1'b1;
      end else if (strb.restart) begin
        addrCnt <= '0;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [ADDR_W-1:0] lastAddr;
  always_ff @(posedge clk) begin
    if (!rstN)     lastAddr <= '0;
    else if (wrEn) lastAddr <= wrAddr;
  end

  assert_addr_seq_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr == '0) || (wrAddr == lastAddr + 1'b1));

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ({1'b0, wrAddr} < (ADDR_W + 1)'(DEPTH)));

endmodule

// File: rtl/frame_downscaler.sv
module frame_downscaler
  import dscale_pkg::*;
#(
  parameter int IN_W       = 640,
  parameter int IN_H       = 480,
  parameter int OUT_W      = 120,
  parameter int OUT_H_STD  = 60,
  parameter int OUT_H_WIDE = 96,
  parameter int PIX_W      = 18,
  localparam int XW     = $clog2(IN_W + 1),
  localparam int YW     = $clog2(IN_H + 1),
  localparam int OH_MAX = (OUT_H_WIDE > OUT_H_STD) ? OUT_H_WIDE : OUT_H_STD,
  localparam int DEPTH  = OUT_W * OH_MAX,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inSol,
  input  logic [PIX_W-1:0]  inPix,
  input  logic              modeWide,
  input  logic              freeze,
  input  logic              zoomEn,
  input  logic [XW-1:0]     cropX,
  input  logic [YW-1:0]     cropY,
  input  logic [XW-1:0]     cropW,
  input  logic [YW-1:0]     cropH,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PIX_W-1:0]  wrData
);

  dscale_strb_t strb;

  dscale_ctrl #(
    .IN_W(IN_W), .IN_H(IN_H), .OUT_W(OUT_W),
    .OUT_H_STD(OUT_H_STD), .OUT_H_WIDE(OUT_H_WIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .modeWide(modeWide), .freeze(freeze), .zoomEn(zoomEn),
    .cropX(cropX), .cropY(cropY), .cropW(cropW), .cropH(cropH),
    .strb(strb)
  );

  dscale_datapath #(
    .PIX_W(PIX_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPix(inPix), .strb(strb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: tb/tb_frame_downscaler.sv
module tb_frame_downscaler;

  localparam int IN_W = 16, IN_H = 12, OUT_W = 5, OH_S = 3, OH_W = 7, PIX_W = 18;
  localparam int XW = $clog2(IN_W + 1), YW = $clog2(IN_H + 1);
  localparam int AW = $clog2(OUT_W * OH_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inSol = 1'b0;
  logic [PIX_W-1:0] inPix = '0;
  logic modeWide = 1'b0, freeze = 1'b0, zoomEn = 1'b0;
  logic [XW-1:0] cropX = '0, cropW = '0;
  logic [YW-1:0] cropY = '0, cropH = '0;
  logic wrEn;
  logic [AW-1:0] wrAddr;
  logic [PIX_W-1:0] wrData;

  always #4 clk = ~clk;

  frame_downscaler #(
    .IN_W(IN_W), .IN_H(IN_H), .OUT_W(OUT_W),
    .OUT_H_STD(OH_S), .OUT_H_WIDE(OH_W), .PIX_W(PIX_W)
  ) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .inPix(inPix), .modeWide(modeWide), .freeze(freeze), .zoomEn(zoomEn),
    .cropX(cropX), .cropY(cropY), .cropW(cropW), .cropH(cropH),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  int testN = 0, failN = 0;
  logic [PIX_W-1:0] expData [64];
  int expCount = 0, gotCount = 0, mism = 0;
  int firstBadAddr = -1;
  logic [PIX_W-1:0] firstBadGot = '0, firstBadExp = '0;

  function automatic logic [PIX_W-1:0] pixVal(int x, int y, int seed);
    logic [5:0] a, b, c;
    a = 6'(seed); b = 6'(y); c = 6'(x);
    return {a, b, c};
  endfunction

  function automatic bit keep(int i, int n, int s);
    return ((i + 1) * n) / s > (i * n) / s;
  endfunction

  // Monitor: compare every write with the predicted list.
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (gotCount >= 64 || int'(wrAddr) != gotCount || wrData != expData[gotCount]) begin
        if (mism == 0) begin
          firstBadAddr = int'(wrAddr);
          firstBadGot  = wrData;
          firstBadExp  = (gotCount < 64) ? expData[gotCount] : '0;
        end
        mism++;
      end
      gotCount++;
    end
  end

  task automatic buildExp(bit wide, bit frz, bit zoom, int x, int y, int w, int h, int seed);
    int oh, cx, cy, cw, ch;
    oh = wide ? OH_W : OH_S;
    if (zoom) begin
      cx = (x > IN_W - OUT_W) ? IN_W - OUT_W : x;
      cw = (w < OUT_W) ? OUT_W : w;
      if (cw > IN_W - cx) cw = IN_W - cx;
      cy = (y > IN_H - oh) ? IN_H - oh : y;
      ch = (h < oh) ? oh : h;
      if (ch > IN_H - cy) ch = IN_H - cy;
    end else begin
      cx = 0; cy = 0; cw = IN_W; ch = IN_H;
    end
    expCount = 0;
    if (!frz) begin
      for (int r = 0; r < ch; r++) begin
        if (keep(r, oh, ch)) begin
          for (int c = 0; c < cw; c++) begin
            if (keep(c, OUT_W, cw)) begin
              expData[expCount] = pixVal(cx + c, cy + r, seed);
              expCount++;
            end
          end
        end
      end
    end
  endtask

  task automatic sendFrame(int seed, bit gaps, bit midFlip);
    for (int y = 0; y < IN_H; y++) begin
      for (int x = 0; x < IN_W; x++) begin
        @(negedge clk);
        inValid = 1'b1;
        inSof   = (x == 0 && y == 0);
        inSol   = (x == 0);
        inPix   = pixVal(x, y, seed);
        if (midFlip && y == 0 && x == 1) begin
          modeWide = ~modeWide; freeze = ~freeze; zoomEn = ~zoomEn;
          cropX = 5'd3; cropY = 4'd2; cropW = 5'd7; cropH = 4'd8;
        end
        if (gaps && (x % 3 == 2)) begin
          @(negedge clk);
          inValid = 1'b0; inSof = 1'b0; inSol = 1'b0; inPix = '1;
        end
      end
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0; inSol = 1'b0; inPix = '1;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(string req, bit wide, bit frz, bit zoom,
                          int x, int y, int w, int h, int seed, bit gaps, bit midFlip);
    modeWide = wide; freeze = frz; zoomEn = zoom;
    cropX = XW'(x); cropY = YW'(y); cropW = XW'(w); cropH = YW'(h);
    buildExp(wide, frz, zoom, x, y, w, h, seed);
    gotCount = 0; mism = 0; firstBadAddr = -1;
    sendFrame(seed, gaps, midFlip);
    testN++;
    if (gotCount != expCount || mism != 0) begin
      failN++;
      $display("FAIL %s: writes %0d expected %0d, mismatches %0d (addr %0d got %h exp %h) wide=%0d frz=%0d zoom=%0d x=%0d y=%0d w=%0d h=%0d",
               req, gotCount, expCount, mism, firstBadAddr, firstBadGot, firstBadExp,
               wide, frz, zoom, x, y, w, h);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failN++;
    $display("FAIL watchdog: run did not finish, got 0 expected completion");
    $display("  [TB] %0d tests run, %0d failed", testN, failN);
    $finish;
  end

  initial begin
    int quietBad;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    quietBad = 0;
    repeat (2) begin @(negedge clk); if (wrEn !== 1'b0) quietBad++; end
    rstN = 1'b1;
    repeat (6) begin @(negedge clk); if (wrEn !== 1'b0) quietBad++; end
    testN++;
    if (quietBad != 0) begin
      failN++;
      $display("FAIL R1: wrEn high %0d times while idle, expected 0", quietBad);
    end

    runFrame("R2 R4 R5 full standard", 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 1, 1'b0, 1'b0);
    runFrame("R3 full wide", 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 2, 1'b0, 1'b0);
    runFrame("R10 gapped standard", 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 3, 1'b1, 1'b0);
    runFrame("R10 gapped wide zoom", 1'b1, 1'b0, 1'b1, 2, 1, 11, 9, 4, 1'b1, 1'b0);
    runFrame("R6 frozen frame", 1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 5, 1'b0, 1'b0);
    runFrame("R6 unfrozen again", 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 6, 1'b0, 1'b0);
    runFrame("R7 late change ignored", 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 7, 1'b0, 1'b1);
    runFrame("R7 late unfreeze ignored", 1'b1, 1'b1, 1'b1, 4, 4, 6, 6, 8, 1'b0, 1'b1);
    runFrame("R9 corner past edge", 1'b0, 1'b0, 1'b1, 20, 15, 30, 15, 9, 1'b0, 1'b0);
    runFrame("R9 zero size", 1'b1, 1'b0, 1'b1, 0, 0, 0, 0, 10, 1'b0, 1'b0);

    // R8 / R9 sweep of crop rectangles in both modes
    begin
      int xs[4] = '{0, 3, 11, 20};
      int ws[3] = '{0, 7, 30};
      int ys[3] = '{0, 5, 15};
      int hs[3] = '{3, 8, 15};
      int seed = 11;
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++)
            for (int c = 0; c < 3; c++)
              for (int d = 0; d < 3; d++) begin
                runFrame("R8 R9 crop sweep", m[0], 1'b0, 1'b1, xs[a], ys[c], ws[b], hs[d],
                         seed, 1'b0, 1'b0);
                seed++;
              end
    end

    $display("  [TB] %0d tests run, %0d failed", testN, failN);
    $finish;
  end

endmodule